// File: doc/BRIEF.md
# Pixel to bus cycle formatter

This block sits between a pixel source and the strobe generator of a parallel display bus. It takes pixels of 12, 16, 18 or 24 bits from a valid/ready stream. For each pixel it produces one or more data beats sized to the selected bus width of 8, 9, 12 or 16 lines. It picks the cycle format from the pairing of pixel depth and bus width. The formats are one, two or three beats per pixel, or a packing that carries two pixels in three beats, with the middle beat split between them. Within a pixel, the more significant bits always leave first.

A frame update is started with a pulse on `start`. The block loads a pixel counter with width × height and accepts exactly that many pixels. In immediate mode it begins at once. In triggered mode it waits for a pulse on `ext_trig`. When the last beat of the frame has been taken, it raises `frame_done` for one cycle and returns to idle. Configuration is captured when the update starts.

Top module: `pix_beat_fmt`

## Requirements
- R1: `fmt_code` and `cfg_err` follow the live `cfg_depth`/`cfg_bus`. The depth codes are 0=12, 1=16, 2=18 and 3=24 bits, and the bus codes are 0=8, 1=9, 2=12 and 3=16 lines. Format 0 (one beat per pixel) is used for 12/12 and 16/16. Format 1 (two beats) is used for 16/8, 18/9 and 24/12. Format 2 (three beats) is used for 24/8. Format 3 (two pixels in three beats) is used for 12/8, 18/12 and 24/16. Every other pairing sets `cfg_err`.
- R2: In format 0, each beat carries the pixel's bits in `bus_data` bit 0 upward, and the bits above the bus width are zero.
- R3: In formats 1 and 2, the beats carry successive bus-width slices of the pixel, most significant first. A 16-bit pixel on 8 lines is sent as bits 15:8 then 7:0. A 24-bit pixel on 8 lines is sent as bits 23:16, then 15:8, then 7:0.
- R4: In format 3, with L lines and two adjacent pixels A then B, the three beats are as follows. Beat 1 is the top L bits of A. Beat 2 is the low L/2 bits of A in its upper half and the top L/2 bits of B in its lower half. Beat 3 is the low L bits of B.
- R5: In format 3, when the frame has an odd pixel count, the final lone pixel is paired with an all-zero pixel B and still takes three beats.
- R6: A `start` while `cfg_err` is set is ignored. `busy` stays low, `pix_ready` stays low and no beat is offered.
- R7: An update accepts exactly `frame_w`×`frame_h` pixels. One cycle after the last beat is taken, `frame_done` is high for exactly one cycle and `busy` is low.
- R8: With `trig_mode`=1, no pixel is accepted after `start` until `ext_trig` has pulsed. With `trig_mode`=0, pixels are accepted at once.
- R9: A `start` while `busy` is high has no effect on the running update or its pixel count.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_data` holds its value.
- R11: After reset, `busy`, `bus_valid`, `pix_ready` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 2 | Pixel depth code |
| cfg_bus | input | 2 | Bus width code |
| trig_mode | input | 1 | 0 = start at once, 1 = wait for ext_trig |
| start | input | 1 | Begin a frame update (pulse) |
| ext_trig | input | 1 | External trigger pulse |
| frame_w | input | DIM_W | Frame width in pixels |
| frame_h | input | DIM_W | Frame height in lines |
| pix_valid | input | 1 | Pixel valid |
| pix_ready | output | 1 | Pixel ready |
| pix_data | input | 24 | Pixel, bit 0 upward |
| bus_valid | output | 1 | Beat valid |
| bus_ready | input | 1 | Beat ready |
| bus_data | output | 16 | Beat data, bit 0 upward |
| fmt_code | output | 2 | Cycle format for live configuration |
| cfg_err | output | 1 | Live pairing fits no format |
| busy | output | 1 | Update in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong beat index or a stale pixel register shows up on the very next handshake as a beat that differs from the one predicted from the pixels sent. A lost pending-pixel flag in the packed format shows up as a middle beat that is offered before its second pixel has arrived. A pixel counter that is off by one, or that is reloaded mid-frame, becomes visible later. It appears at the end of the frame as a `pix_ready` with no pixels left, or as a `frame_done` that comes early or late compared with the count of beats taken.

// File: rtl/pix_beat_fmt.sv
module pix_beat_fmt #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_depth,
  input  logic [1:0]       cfg_bus,
  input  logic             trig_mode,
  input  logic             start,
  input  logic             ext_trig,
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [23:0]      pix_data,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [15:0]      bus_data,
  output logic [1:0]       fmt_code,
  output logic             cfg_err,
  output logic             busy,
  output logic             frame_done
);
  localparam int CNT_W = 2 * DIM_W;

  function automatic int lines_of(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 9;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  function automatic int depth_of(input logic [1:0] c);
    case (c)
      2'd0: return 12;
      2'd1: return 16;
      2'd2: return 18;
      default: return 24;
    endcase
  endfunction

  always_comb begin
    cfg_err  = 1'b0;
    fmt_code = 2'd0;
    case ({cfg_depth, cfg_bus})
      4'b00_10, 4'b01_11:          fmt_code = 2'd0;
      4'b01_00, 4'b10_01, 4'b11_10: fmt_code = 2'd1;
      4'b11_00:                    fmt_code = 2'd2;
      4'b00_00, 4'b10_10, 4'b11_11: fmt_code = 2'd3;
      default:                     cfg_err  = 1'b1;
    endcase
  end

  logic             go, hold, need_b;
  logic [1:0]       fq, bq, dq, beat;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      pa, pb;

  wire [1:0]  last    = (fq == 2'd0) ? 2'd0 : (fq == 2'd1) ? 2'd1 : 2'd2;
  wire [31:0] dmask   = (32'd1 << depth_of(dq)) - 32'd1;
  wire [31:0] pix_in  = {8'd0, pix_data} & dmask;

  assign pix_ready = busy && go && (cnt != '0) && (!hold || need_b);
  assign bus_valid = hold && !(need_b && beat != 2'd0);
  wire pix_fire = pix_valid && pix_ready;
  wire bus_fire = bus_valid && bus_ready;

  always_comb begin
    int ln, hl;
    logic [31:0] ml, w;
    ln = lines_of(bq);
    hl = ln / 2;
    ml = (32'd1 << ln) - 32'd1;
    if (fq == 2'd3) begin
      case (beat)
        2'd0:    w = (pa >> hl) & ml;
        2'd1:    w = ((pa & ((32'd1 << hl) - 32'd1)) << hl) | (pb >> ln);
        default: w = pb & ml;
      endcase
    end else begin
      w = (pa >> (ln * (int'(last) - int'(beat)))) & ml;
    end
    bus_data = w[15:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; go <= 1'b0; hold <= 1'b0; need_b <= 1'b0;
      frame_done <= 1'b0; beat <= '0; cnt <= '0;
      fq <= '0; bq <= '0; dq <= '0; pa <= '0; pb <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        if (start && !cfg_err) begin
          busy   <= 1'b1;
          go     <= !trig_mode;
          cnt    <= CNT_W'(frame_w) * CNT_W'(frame_h);
          fq     <= fmt_code;
          bq     <= cfg_bus;
          dq     <= cfg_depth;
          hold   <= 1'b0;
          need_b <= 1'b0;
          beat   <= '0;
        end
      end else begin
        if (!go && ext_trig) go <= 1'b1;
        if (pix_fire) begin
          cnt <= cnt - CNT_W'(1);
          if (hold) begin
            pb     <= pix_in;
            need_b <= 1'b0;
          end else begin
            pa   <= pix_in;
            hold <= 1'b1;
            beat <= '0;
            if (fq == 2'd3 && cnt != CNT_W'(1)) need_b <= 1'b1;
            else pb <= '0;
          end
        end
        if (bus_fire) begin
          if (beat == last) hold <= 1'b0;
          else beat <= beat + 2'd1;
        end
        if (go && cnt == '0 && !hold) begin
          busy       <= 1'b0;
          go         <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data)); // R10
  AST_ERR_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && cfg_err |=> !busy); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !pix_ready && !bus_valid && !busy); // R7
  AST_TRIG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && trig_mode && !cfg_err |=> !pix_ready); // R8
endmodule

// File: tb/sim_pix_beat_fmt.sv
module sim_pix_beat_fmt;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [1:0]  cfg_depth = 0, cfg_bus = 0;
  logic        trig_mode = 0, start = 0, ext_trig = 0;
  logic [11:0] frame_w = 0, frame_h = 0;
  logic        pix_valid = 0, pix_ready;
  logic [23:0] pix_data = 0;
  logic        bus_valid, bus_ready = 1;
  logic [15:0] bus_data;
  logic [1:0]  fmt_code;
  logic        cfg_err, busy, frame_done;

  pix_beat_fmt u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rem = 0, pidx = 0, seed = 0;
  int m_d = 12, m_l = 8, m_f = 0;
  bit bp_en = 0, acc = 0, have_a = 0, prev_stall = 0;
  logic [31:0] m_a = 0;
  logic [15:0] prev_data = 0;
  int q[$];
  string tag = "R2";

  task automatic chk(input bit ok, input string t, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", t, what, got, exp);
    end
  endtask

  function automatic logic [23:0] gen(input int i);
    logic [31:0] v;
    v = (i + seed) * 32'h9E3779B + 32'h5A5A5;
    return v[23:0];
  endfunction

  function automatic int dep(input int c); return c == 0 ? 12 : c == 1 ? 16 : c == 2 ? 18 : 24; endfunction
  function automatic int lin(input int c); return c == 0 ? 8 : c == 1 ? 9 : c == 2 ? 12 : 16; endfunction

  // model: expected beats from accepted pixels
  task automatic model_pixel(input logic [23:0] raw);
    logic [31:0] p, ml, hm;
    int nb;
    p  = {8'd0, raw} & ((32'd1 << m_d) - 1);
    ml = (32'd1 << m_l) - 1;
    hm = (32'd1 << (m_l / 2)) - 1;
    if (m_f < 3) begin
      nb = m_f + 1;
      for (int k = 0; k < nb; k++) q.push_back(int'((p >> (m_l * (nb - 1 - k))) & ml));
    end else if (!have_a) begin
      q.push_back(int'((p >> (m_d - m_l)) & ml));
      if (rem == 1) begin
        q.push_back(int'((p & hm) << (m_l / 2)));
        q.push_back(0);
      end else begin
        have_a = 1;
        m_a = p;
      end
    end else begin
      q.push_back(int'(((m_a & hm) << (m_l / 2)) | (p >> (m_d - m_l / 2))));
      q.push_back(int'(p & ml));
      have_a = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R7", "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (rst_n) begin
      if (prev_stall) begin
        chk(bus_valid === 1'b1, "R10", "valid dropped under stall", bus_valid, 1);
        chk(bus_data === prev_data, "R10", "data moved under stall", bus_data, prev_data);
      end
      prev_stall = bus_valid && !bus_ready;
      prev_data  = bus_data;
      if (bus_valid && bus_ready) begin
        if (q.size() == 0) chk(0, tag, "unexpected beat", bus_data, -1);
        else begin
          int e;
          e = q.pop_front();
          chk(int'(bus_data) == e, tag, "beat data", bus_data, e);
        end
      end
      if (pix_ready && rem == 0) chk(0, "R7", "pix_ready with no pixels left", 1, 0);
      if (pix_valid && pix_ready) begin
        model_pixel(pix_data);
        rem--;
        pidx++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    pix_data  = gen(pidx);
    pix_valid = rem > 0;
    bus_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic run_frame(input int dc, input int bc, input int fmt, input int w, input int h,
                           input string t, input bit bp, input bit trig, input bit restart);
    int n;
    @(posedge clk); #1;
    cfg_depth = 2'(dc); cfg_bus = 2'(bc); frame_w = 12'(w); frame_h = 12'(h);
    trig_mode = trig; bp_en = bp; tag = t;
    m_d = dep(dc); m_l = lin(bc); m_f = fmt; have_a = 0; q.delete();
    seed = seed + 17; pidx = 0; rem = w * h;
    pulse_start();
    if (trig) begin
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(busy === 1 && pix_ready === 0 && rem == w * h, "R8", "waiting for trigger", pix_ready, 0);
      @(posedge clk); #1 ext_trig = 1;
      @(posedge clk); #1 ext_trig = 0;
    end
    if (restart) begin
      repeat (3) @(posedge clk);
      #1 frame_w = 12'(w + 5);
      pulse_start();
    end
    n = 0;
    @(negedge clk);
    while (!frame_done && n < 5000) begin @(negedge clk); n++; end
    chk(frame_done === 1, t, "frame_done seen", frame_done, 1);
    chk(busy === 0, "R7", "busy low at done", busy, 0);
    chk(rem == 0 && q.size() == 0, "R7", "all pixels and beats consumed", rem + q.size(), 0);
    @(negedge clk);
    chk(frame_done === 0, "R7", "done one cycle", frame_done, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 0 && bus_valid === 0 && pix_ready === 0 && frame_done === 0, "R11", "reset outputs",
        {busy, bus_valid, pix_ready, frame_done}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && bus_valid === 0 && pix_ready === 0, "R11", "idle after reset", busy, 0);

    for (int dc = 0; dc < 4; dc++)
      for (int bc = 0; bc < 4; bc++) begin
        int b, l, ef;
        bit ee;
        b = dep(dc); l = lin(bc); ee = 0; ef = 0;
        if (b % l == 0 && b / l >= 1 && b / l <= 3) ef = b / l - 1;
        else if ((2 * b) % l == 0 && (2 * b) / l == 3) ef = 3;
        else ee = 1;
        @(posedge clk); #1 cfg_depth = 2'(dc); cfg_bus = 2'(bc);
        @(negedge clk);
        chk(cfg_err === ee, "R1", "cfg_err", cfg_err, ee);
        if (!ee) chk(int'(fmt_code) == ef, "R1", "fmt_code", fmt_code, ef);
      end

    run_frame(1, 3, 0, 3, 2, "R2", 0, 0, 0);
    run_frame(0, 2, 0, 4, 1, "R2", 1, 0, 0);
    run_frame(1, 0, 1, 3, 3, "R3", 1, 0, 0);
    run_frame(3, 0, 2, 5, 1, "R3", 0, 0, 0);
    run_frame(2, 1, 1, 2, 3, "R3", 1, 0, 0);
    run_frame(3, 2, 1, 3, 1, "R3", 0, 0, 0);
    run_frame(0, 0, 3, 2, 2, "R4", 1, 0, 0);
    run_frame(2, 2, 3, 4, 1, "R4", 0, 0, 0);
    run_frame(3, 3, 3, 3, 1, "R5", 1, 0, 0);
    run_frame(0, 0, 3, 1, 1, "R5", 0, 0, 0);
    run_frame(1, 0, 1, 4, 2, "R8", 1, 1, 0);
    run_frame(3, 0, 2, 6, 2, "R9", 1, 0, 1);

    @(posedge clk); #1 cfg_depth = 2'd0; cfg_bus = 2'd1; frame_w = 4; frame_h = 4; trig_mode = 0;
    q.delete();
    pulse_start();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(busy === 0 && pix_ready === 0 && bus_valid === 0, "R6", "start with bad pairing",
          {busy, pix_ready, bus_valid}, 0);
    end

    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule